// File: doc/BRIEF.md
# Pulse-Synchronous Uplink Command Decoder

This block listens to a single-wire serial uplink that carries one 16-bit word per radar pulse. The line idles low. At the start of each pulse it goes high for a burst window, and the data bits follow. The block does not recover bit timing from start bits. Instead, it places every bit at a fixed offset from the falling edge that closes the burst window, using the acquisition-rate clock. The first bit is sampled half a bit period after that edge, and each later bit one full bit period after the one before it.

A received word splits into a 4-bit command field and a 12-bit data field. Three command codes update a bank of 25 latched output levels, each code writing its own slice of the bank. Words of any other code, such as the clock-locking words that share the stream, are accepted but change nothing. Each accepted word raises a one-cycle strobe. A malformed word raises a one-cycle framing-error flag and is dropped.

The outputs are plain status levels and strobes with no ready input. The block cannot be stalled, so a consumer that wants each word must sample on the strobe cycle. The next word cannot arrive sooner than a full word time later.

Top module: `uplink_cmd_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pins_out` is all zero and `word_valid` and `frame_err` are low.
- R2: A word begins with a rising edge of `line_in`, which must then stay high for at least 16 clocks. It closes with a falling edge. Bit k (k = 0..15) is sampled 64 + 128·k clocks after that falling edge. Bits arrive most significant first, so bit 0 is word bit 15. The command is word bits 15..12 and the data is bits 11..0.
- R3: Command code 1 loads `pins_out[11:0]` from data bits 11..0 and leaves `pins_out[24:12]` unchanged.
- R4: Command code 2 loads `pins_out[23:12]` from data bits 11..0 and leaves the other outputs unchanged.
- R5: Command code 3 loads `pins_out[24]` from data bit 0 and leaves `pins_out[23:0]` unchanged.
- R6: Any other command code, 0 or 4..15 (including clock-locking words), pulses `word_valid` and leaves every output unchanged.
- R7: A high level on `line_in` that lasts fewer than 16 clocks is ignored: no word, no framing error and no output change.
- R8: A rising edge of `line_in` during data sampling is a framing error when it falls more than 32 clocks from a bit boundary. The boundaries are multiples of 128 clocks after the closing falling edge. On such an edge, `frame_err` pulses for one cycle, no `word_valid` follows, and the outputs keep their values. The decoder then waits for a new burst.
- R9: `word_valid` is high for exactly one cycle per completed word, shortly after the sixteenth bit is sampled. `pins_out` changes only in a cycle where `word_valid` is high, and the new value appears in that same cycle.
- R10: A level left high by the last data bit is not a burst. A new word requires a fresh rising edge after the word ends.
- R11: Output-update words and other words may arrive in any order. Each word acts only on its own slice, so the bank holds the most recent data written to each slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Acquisition-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Serial uplink line, asynchronous to `clk`; synchronised internally |
| pins_out | output | 25 | Latched output levels |
| word_valid | output | 1 | One-cycle strobe per completed word |
| frame_err | output | 1 | One-cycle pulse when a word is dropped for bad framing |

## Verification
A phase counter that slips would sample neighbouring bits. That shows within a single word as a wrong slice on `pins_out`, or as a spurious `frame_err` when a legal bit edge lands in the forbidden middle region. A wrong burst qualifier shows as an extra or missing `word_valid` in the glitch and trailing-high scenarios, within one word time of the event. A corrupted output register shows as a slice that changes without a strobe, or that holds a stale value after its own command. This is visible on the cycle of the next strobe.

// File: rtl/uplink_pkg.sv
package uplink_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_BURST = 2'd1,
    FR_DATA  = 2'd2
  } fr_state_t;
endpackage

// File: rtl/uplink_sync.sv
module uplink_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uplink_framer.sv
module uplink_framer
  import uplink_pkg::*;
#(
  parameter int BIT_CLKS  = 128,
  parameter int MIN_BURST = 16,
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_s,
  output logic [WORD_BITS-1:0] word_q,
  output logic                 word_done,
  output logic                 frame_err
);
  localparam int PH_W  = $clog2(BIT_CLKS);
  localparam int CNT_W = $clog2(MIN_BURST + 1);
  localparam int IDX_W = $clog2(WORD_BITS);
  localparam logic [PH_W-1:0]  PH_HALF = PH_W'(BIT_CLKS / 2);
  localparam logic [PH_W-1:0]  PH_QLO  = PH_W'(BIT_CLKS / 4);
  localparam logic [PH_W-1:0]  PH_QHI  = PH_W'(BIT_CLKS - BIT_CLKS / 4);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(BIT_CLKS - 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_BURST);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_BITS - 1);

  fr_state_t        state_q;
  logic             line_d;
  logic [CNT_W-1:0] burst_cnt;
  logic [PH_W-1:0]  phase_q;
  logic [IDX_W-1:0] bit_idx;

  logic rise, fall, mid_region;
  assign rise       = line_s & ~line_d;
  assign fall       = ~line_s & line_d;
  assign mid_region = (phase_q >= PH_QLO) && (phase_q < PH_QHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= FR_IDLE;
      line_d    <= 1'b0;
      burst_cnt <= '0;
      phase_q   <= '0;
      bit_idx   <= '0;
      word_q    <= '0;
      word_done <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      line_d    <= line_s;
      word_done <= 1'b0;
      frame_err <= 1'b0;
      unique case (state_q)
        FR_IDLE: begin
          if (rise) begin
            state_q   <= FR_BURST;
            burst_cnt <= CNT_W'(1);
          end
        end
        FR_BURST: begin
          if (fall) begin
            if (burst_cnt >= CNT_MIN) begin
              state_q <= FR_DATA;
              phase_q <= PH_W'(1);
              bit_idx <= '0;
            end else begin
              state_q <= FR_IDLE;
            end
          end else if (burst_cnt != CNT_MIN) begin
            burst_cnt <= burst_cnt + CNT_W'(1);
          end
        end
        FR_DATA: begin
          phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
          if (rise && mid_region) begin
            frame_err <= 1'b1;
            state_q   <= FR_IDLE;
          end else if (phase_q == PH_HALF) begin
            word_q <= {word_q[WORD_BITS-2:0], line_s};
            if (bit_idx == IDX_LAST) begin
              word_done <= 1'b1;
              state_q   <= FR_IDLE;
            end else begin
              bit_idx <= bit_idx + IDX_W'(1);
            end
          end
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uplink_out_bank.sv
module uplink_out_bank #(
  parameter int WORD_BITS = 16,
  parameter int CMD_BITS  = 4,
  parameter int NUM_OUTS  = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_BITS-1:0] word,
  input  logic                 word_done,
  output logic [NUM_OUTS-1:0]  pins,
  output logic                 valid
);
  localparam int DATA_BITS  = WORD_BITS - CMD_BITS;
  localparam int NUM_GROUPS = (NUM_OUTS + DATA_BITS - 1) / DATA_BITS;

  logic [CMD_BITS-1:0] cmd;
  assign cmd = word[WORD_BITS-1:DATA_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= word_done;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = g * DATA_BITS;
    localparam int W  = (NUM_OUTS - LO < DATA_BITS) ? (NUM_OUTS - LO) : DATA_BITS;
    logic [W-1:0] grp_q;

    always_ff @(posedge clk) begin
      if (!rst_n)
        grp_q <= '0;
      else if (word_done && cmd == CMD_BITS'(g + 1))
        grp_q <= word[W-1:0];
    end

    assign pins[LO +: W] = grp_q;
  end
endmodule

// File: rtl/uplink_cmd_decoder.sv
module uplink_cmd_decoder #(
  parameter int BIT_CLKS    = 128,
  parameter int MIN_BURST   = 16,
  parameter int WORD_BITS   = 16,
  parameter int CMD_BITS    = 4,
  parameter int NUM_OUTS    = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_in,
  output logic [NUM_OUTS-1:0] pins_out,
  output logic                word_valid,
  output logic                frame_err
);
  logic                 line_s;
  logic [WORD_BITS-1:0] word_q;
  logic                 word_done;

  uplink_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din (line_in),
    .dout (line_s)
  );

  uplink_framer #(
    .BIT_CLKS (BIT_CLKS),
    .MIN_BURST (MIN_BURST),
    .WORD_BITS (WORD_BITS)
  ) u_framer (
    .clk (clk),
    .rst_n (rst_n),
    .line_s (line_s),
    .word_q (word_q),
    .word_done (word_done),
    .frame_err (frame_err)
  );

  uplink_out_bank #(
    .WORD_BITS (WORD_BITS),
    .CMD_BITS (CMD_BITS),
    .NUM_OUTS (NUM_OUTS)
  ) u_bank (
    .clk (clk),
    .rst_n (rst_n),
    .word (word_q),
    .word_done (word_done),
    .pins (pins_out),
    .valid (word_valid)
  );
endmodule

// File: rtl/uplink_cmd_decoder_chk.sv
module uplink_cmd_decoder_chk #(
  parameter int WORD_BITS = 16,
  parameter int CMD_BITS  = 4,
  parameter int NUM_OUTS  = 25
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_OUTS-1:0]  pins_out,
  input logic                 word_valid,
  input logic                 frame_err,
  input logic [WORD_BITS-1:0] word_q
);
  localparam int DB = WORD_BITS - CMD_BITS;

  logic [CMD_BITS-1:0] cmd;
  assign cmd = word_q[WORD_BITS-1:DB];

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  a_r9_pins_only_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pins_out) |-> word_valid);
  a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  a_r8_err_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !word_valid);
  a_r6_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && cmd != CMD_BITS'(1) && cmd != CMD_BITS'(2) && cmd != CMD_BITS'(3))
      |-> $stable(pins_out));
  a_r3_cmd1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && cmd == CMD_BITS'(1))
      |-> (pins_out[DB-1:0] == word_q[DB-1:0]) && $stable(pins_out[NUM_OUTS-1:DB]));
  a_r4_cmd2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && cmd == CMD_BITS'(2))
      |-> (pins_out[2*DB-1:DB] == word_q[DB-1:0]) && $stable(pins_out[DB-1:0])
          && $stable(pins_out[NUM_OUTS-1:2*DB]));
  a_r5_cmd3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && cmd == CMD_BITS'(3))
      |-> (pins_out[NUM_OUTS-1:2*DB] == word_q[NUM_OUTS-2*DB-1:0])
          && $stable(pins_out[2*DB-1:0]));
endmodule

bind uplink_cmd_decoder uplink_cmd_decoder_chk #(
  .WORD_BITS (WORD_BITS),
  .CMD_BITS (CMD_BITS),
  .NUM_OUTS (NUM_OUTS)
) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .pins_out (pins_out),
  .word_valid (word_valid),
  .frame_err (frame_err),
  .word_q (word_q)
);

// File: tb/uplink_cmd_decoder_bench.sv
`timescale 1ns/1ps
module uplink_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_in = 1'b0;
  logic [24:0] pins_out;
  logic        word_valid, frame_err;

  int n_checks = 0, n_errors = 0;
  int n_wv = 0, n_fe = 0, bad_change = 0, bad_width = 0;
  logic [24:0] exp_pins = '0;
  logic [24:0] prev_pins = '0;
  logic        prev_wv = 1'b0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  uplink_cmd_decoder u_uplink_cmd_decoder (
    .clk (clk), .rst_n (rst_n), .line_in (line_in),
    .pins_out (pins_out), .word_valid (word_valid), .frame_err (frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) n_wv++;
      if (frame_err) n_fe++;
      if (pins_out !== prev_pins && !word_valid) bad_change++;
      if (word_valid && prev_wv) bad_width++;
    end
    prev_pins = pins_out;
    prev_wv   = word_valid;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic v, input int n);
    @(negedge clk);
    line_in = v;
    repeat (n - 1) @(negedge clk);
  endtask

  // burst, then bits MSB first; bit 0 opens with a short low so the burst end is visible
  task automatic send_word(input int burst, input logic [15:0] w, input bit hold_tail);
    drive(1'b1, burst);
    drive(1'b0, 2);
    drive(w[15], 126);
    for (int i = 14; i >= 0; i--) drive(w[i], 128);
    if (hold_tail) drive(line_in, 300);
    drive(1'b0, 40);
  endtask

  function automatic logic [24:0] model(input logic [24:0] cur, input logic [15:0] w);
    logic [24:0] r = cur;
    case (w[15:12])
      4'd1: r[11:0]  = w[11:0];
      4'd2: r[23:12] = w[11:0];
      4'd3: r[24]    = w[0];
      default: ;
    endcase
    return r;
  endfunction

  task automatic word_and_check(input string req, input int burst, input logic [15:0] w);
    int wv0 = n_wv;
    send_word(burst, w, 1'b0);
    exp_pins = model(exp_pins, w);
    check(n_wv == wv0 + 1, req, "strobe count", n_wv - wv0, 1);
    check(pins_out == exp_pins, req, "pins", pins_out, exp_pins);
  endtask

  task automatic t_reset;
    check(pins_out == '0, "R1", "pins at reset", pins_out, 0);
    check(!word_valid && !frame_err, "R1", "flags at reset", {word_valid, frame_err}, 0);
    rst_n = 1'b1;
    idle(1);
    check(pins_out == '0 && !word_valid && !frame_err, "R1", "after release",
          {word_valid, frame_err, pins_out}, 0);
  endtask

  task automatic t_commands;
    word_and_check("R3", 20, 16'h19C3);   // asymmetric data checks MSB-first order (R2)
    word_and_check("R4", 20, 16'h2A5F);
    word_and_check("R5", 20, 16'h3001);
    word_and_check("R5", 20, 16'h3FFE);   // only data bit 0 matters
    word_and_check("R5", 20, 16'h3001);
  endtask

  task automatic t_other_codes;
    word_and_check("R6", 20, 16'h0FFF);
    word_and_check("R6", 20, 16'h8ABC);   // clock-locking style word
    word_and_check("R6", 20, 16'hF123);
  endtask

  task automatic t_burst_min;
    int wv0 = n_wv, fe0 = n_fe;
    drive(1'b1, 15);
    drive(1'b0, 2200);
    check(n_wv == wv0 && n_fe == fe0, "R7", "15-clock glitch", n_wv - wv0, 0);
    check(pins_out == exp_pins, "R7", "pins after glitch", pins_out, exp_pins);
    word_and_check("R2", 16, 16'h1555);   // exactly 16 clocks accepted
  endtask

  task automatic t_frame_error;
    int wv0 = n_wv, fe0 = n_fe;
    drive(1'b1, 20);
    drive(1'b0, 2);
    drive(1'b0, 126);
    drive(1'b0, 128);
    drive(1'b0, 60);
    drive(1'b1, 10);                      // rise mid-bit
    drive(1'b0, 2200);
    check(n_fe == fe0 + 1, "R8", "error pulses", n_fe - fe0, 1);
    check(n_wv == wv0, "R8", "no strobe", n_wv - wv0, 0);
    check(pins_out == exp_pins, "R8", "pins held", pins_out, exp_pins);
    word_and_check("R8", 20, 16'h2123);   // recovers on the next burst
  endtask

  task automatic t_tail_high;
    int wv0 = n_wv;
    send_word(20, 16'h1FFF, 1'b1);
    exp_pins = model(exp_pins, 16'h1FFF);
    drive(1'b0, 2200);
    check(n_wv == wv0 + 1, "R10", "trailing high not a burst", n_wv - wv0, 1);
    check(pins_out == exp_pins, "R10", "pins", pins_out, exp_pins);
  endtask

  task automatic t_mixed;
    word_and_check("R11", 24, 16'h2000);
    word_and_check("R11", 24, 16'h8001);
    word_and_check("R11", 24, 16'h1ABC);
    word_and_check("R11", 24, 16'h3000);
    word_and_check("R11", 24, 16'h2FED);
    check(pins_out == 25'h0FEDABC, "R11", "final bank", pins_out, 25'h0FEDABC);
  endtask

  initial begin
    idle(4);
    t_reset();
    t_commands();
    t_other_codes();
    t_burst_min();
    t_frame_error();
    t_tail_high();
    t_mixed();
    check(bad_change == 0, "R9", "pins changed without strobe", bad_change, 0);
    check(bad_width == 0, "R9", "strobe wider than one cycle", bad_width, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule